// File: doc/BRIEF.md
# LPC Memory-Cycle Target

This block is the target end of Low Pin Count memory read and memory write cycles. The host drives a 4-bit multiplexed bus and an active-low frame strobe. The block finds a valid start nibble and reads the cycle type. It then shifts in a 32-bit address one nibble per clock and decides whether the access is its own. That decision uses an upper-range check, a memory/register select bit and a four-bit device ID compared against strap inputs.

On a claimed write, the block takes one data byte, waits out the host turnaround, answers with a ready SYNC and hands the bus back. On a claimed read, it waits out the turnaround, answers with SYNC, returns one byte from a small internal memory or register model and hands the bus back. Cycles it does not claim leave the bus untouched. A frame strobe that arrives in the middle of a cycle cancels the cycle.

Top module: `lpc_mem_target`

## Requirements
- R1: While `frame_n` is low the bus nibble is sampled on every rising edge. The start value is the nibble sampled on the last clock with `frame_n` low, and only 4'b0000 starts a cycle.
- R2: A cycle with a non-zero start value is ignored. The block never drives the bus for it and no storage changes.
- R3: The nibble on the first clock after the frame is the cycle type: 4'b0100 is a memory read and 4'b0110 is a memory write. Any other value makes the block ignore the cycle.
- R4: `sel_n` must be low on the clock before the last frame-low clock, or the cycle is ignored.
- R5: Eight address nibbles follow the cycle type, most significant first. The block claims the access only if address bits 31:25 are all ones or all zeros.
- R6: The device ID {addr[24], addr[23], addr[21], addr[20]} must equal `strap_id`, or the access is ignored.
- R7: addr[22]=1 selects memory, indexed by addr[MEM_AW-1:0]. addr[22]=0 selects the register space, indexed by addr[REG_AW-1:0]. The two spaces are separate storage.
- R8: On a claimed write, two data nibbles follow the address, low nibble first. Then come two host turnaround clocks and one SYNC clock, during which the block drives 4'b0000. The byte is stored at the end of the SYNC clock.
- R9: On a claimed read, two host turnaround clocks follow the address. The block then drives SYNC 4'b0000, then the low data nibble, then the high data nibble.
- R10: Every claimed cycle ends with a two-clock target turnaround: 4'b1111 driven on the first clock, bus released on the second. `lad_oe` is high only during SYNC, read data and that first clock. While released, `lad_out` reads 4'b0000.
- R11: A low `frame_n` during a cycle aborts it. The bus is released on the next clock, start detection begins again, and a write aborted on or before its SYNC clock stores nothing.
- R12: After reset the bus is released and all memory and register locations read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame strobe from the host |
| lad_in | input | 4 | Nibble sampled from the bus |
| lad_out | output | 4 | Nibble the target drives |
| lad_oe | output | 1 | High while the target drives the bus |
| sel_n | input | 1 | Active-low device select |
| strap_id | input | 4 | Strapped device ID |

## Verification
A wrong internal state shows at the ports as a misplaced `lad_oe` window or as a wrong nibble inside it. The bench therefore records the six clocks after the host's last nibble of every cycle and compares that bus picture against the expected one. A bad decode or phase count shows up in the same cycle, as missing, extra or shifted drive. A corrupted or lost write only shows when the location is read later. The random mix therefore reads locations back against a model, and every ignored or aborted cycle is followed by a read-back.

// File: rtl/lpc_mem_target.sv
module lpc_mem_target #(
  parameter int MEM_AW = 6,
  parameter int REG_AW = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_n,
  input  logic [3:0] lad_in,
  output logic [3:0] lad_out,
  output logic       lad_oe,
  input  logic       sel_n,
  input  logic [3:0] strap_id
);
  localparam int MEM_WORDS = 1 << MEM_AW;
  localparam int REG_WORDS = 1 << REG_AW;
  localparam int ADDR_NIBS = 8;
  localparam int CW = $clog2(ADDR_NIBS);
  localparam logic [3:0] TYPE_RD = 4'b0100;
  localparam logic [3:0] TYPE_WR = 4'b0110;

  typedef enum logic [3:0] {
    IDLE, START, ADDR, WDAT0, WDAT1, HTAR0, HTAR1,
    SYNC, RDAT0, RDAT1, TTAR0, TTAR1
  } st_t;

  st_t          st;
  logic [3:0]   start_q;
  logic         sel_d, sel_ok, is_wr;
  logic [CW-1:0] cnt;
  logic [31:0]  addr;
  logic [7:0]   wbyte;
  logic [7:0]   mem  [MEM_WORDS];
  logic [7:0]   regs [REG_WORDS];

  logic [31:0] addr_full;
  logic        upper_ok, id_ok, type_ok, wr_en;
  logic [7:0]  rd_byte;

  assign addr_full = {addr[27:0], lad_in};
  assign upper_ok  = (&addr_full[31:25]) | ~(|addr_full[31:25]);
  assign id_ok     = {addr_full[24:23], addr_full[21:20]} == strap_id;
  assign type_ok   = (lad_in == TYPE_RD) || (lad_in == TYPE_WR);
  assign wr_en     = (st == SYNC) && is_wr && frame_n;
  assign rd_byte   = addr[22] ? mem[addr[MEM_AW-1:0]] : regs[addr[REG_AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      start_q <= 4'hF;
      sel_d   <= 1'b1;
      sel_ok  <= 1'b0;
      is_wr   <= 1'b0;
      cnt     <= '0;
      addr    <= '0;
      wbyte   <= '0;
    end else begin
      sel_d <= sel_n;
      if (!frame_n) begin
        st      <= START;
        start_q <= lad_in;
        sel_ok  <= !sel_d;
      end else begin
        case (st)
          START: begin
            cnt <= '0;
            if (start_q == 4'h0 && sel_ok && type_ok) begin
              st    <= ADDR;
              is_wr <= lad_in[1];
            end else begin
              st <= IDLE;
            end
          end
          ADDR: begin
            addr <= addr_full;
            cnt  <= cnt + 1'b1;
            if (cnt == CW'(ADDR_NIBS - 1))
              st <= (upper_ok && id_ok) ? (is_wr ? WDAT0 : HTAR0) : IDLE;
          end
          WDAT0: begin wbyte[3:0] <= lad_in; st <= WDAT1; end
          WDAT1: begin wbyte[7:4] <= lad_in; st <= HTAR0; end
          HTAR0: st <= HTAR1;
          HTAR1: st <= SYNC;
          SYNC:  st <= is_wr ? TTAR0 : RDAT0;
          RDAT0: st <= RDAT1;
          RDAT1: st <= TTAR0;
          TTAR0: st <= TTAR1;
          TTAR1: st <= IDLE;
          default: st <= IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_WORDS; i++) mem[i] <= '0;
      for (int i = 0; i < REG_WORDS; i++) regs[i] <= '0;
    end else if (wr_en) begin
      if (addr[22]) mem[addr[MEM_AW-1:0]]  <= wbyte;
      else          regs[addr[REG_AW-1:0]] <= wbyte;
    end
  end

  always_comb begin
    lad_oe  = 1'b1;
    lad_out = 4'h0;
    case (st)
      SYNC:  lad_out = 4'h0;
      RDAT0: lad_out = rd_byte[3:0];
      RDAT1: lad_out = rd_byte[7:4];
      TTAR0: lad_out = 4'hF;
      default: lad_oe = 1'b0;
    endcase
  end

  a_r2_bad_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (st == START && frame_n && start_q != 4'h0) |=> (st == IDLE && !lad_oe));

  a_r11_abort_releases: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> !lad_oe);

  a_r9_first_drive_is_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lad_oe) |-> lad_out == 4'h0);

  a_r10_release_after_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TTAR0) |=> !lad_oe);

  a_r8_write_during_sync: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (lad_oe && lad_out == 4'h0));
endmodule

// File: tb/sim_lpc_mem_target.sv
module sim_lpc_mem_target;
  localparam int MEM_AW = 6;
  localparam int REG_AW = 2;
  localparam logic [3:0] ID = 4'b1010;

  logic clk = 0, rst_n = 0, frame_n = 1, sel_n = 1;
  logic [3:0] lad_in = 4'hF, lad_out, strap_id = ID;
  logic lad_oe;
  int checks = 0, errors = 0;
  logic obs_oe;
  logic [3:0] obs_out;
  logic [7:0] bmem [1 << MEM_AW];
  logic [7:0] breg [1 << REG_AW];

  always #5 clk = ~clk;

  lpc_mem_target #(.MEM_AW(MEM_AW), .REG_AW(REG_AW)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_in(lad_in),
    .lad_out(lad_out), .lad_oe(lad_oe), .sel_n(sel_n), .strap_id(strap_id));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic f, input logic [3:0] d, input logic s);
    @(negedge clk); #1;
    obs_oe = lad_oe; obs_out = lad_out;
    frame_n = f; lad_in = d; sel_n = s;
  endtask

  function automatic logic [31:0] mk_addr(input logic [6:0] up, input logic [3:0] id,
                                          input logic sp, input logic [19:0] low);
    return {up, id[3:2], sp, id[1:0], low};
  endfunction

  function automatic logic hit(input logic [31:0] a);
    return ((&a[31:25]) || !(|a[31:25])) && ({a[24:23], a[21:20]} == ID);
  endfunction

  function automatic logic [29:0] exp_pat(input logic claimed, input logic wr, input logic [7:0] rd);
    if (!claimed) return '0;
    if (wr) return {5'h10, 5'h1F, 20'h0};
    return {5'h10, 1'b1, rd[3:0], 1'b1, rd[7:4], 5'h1F, 10'h0};
  endfunction

  function automatic logic [7:0] model_rd(input logic [31:0] a);
    return a[22] ? bmem[a[MEM_AW-1:0]] : breg[a[REG_AW-1:0]];
  endfunction

  task automatic run_cycle(input logic wr, input logic [31:0] a, input logic [7:0] wd,
                           input logic sel_early, input logic use_pre, input logic [3:0] pre,
                           input logic [3:0] start, input logic [3:0] cyc,
                           output logic [29:0] pat);
    step(1, 4'hF, !sel_early);
    if (use_pre) step(0, pre, 0);
    step(0, start, 0);
    step(1, cyc, 0);
    for (int i = 0; i < 8; i++) step(1, a[31-4*i -: 4], 0);
    if (wr) begin step(1, wd[3:0], 0); step(1, wd[7:4], 0); end
    step(1, 4'hF, 0); step(1, 4'hF, 0);
    for (int k = 0; k < 6; k++) begin
      step(1, 4'hF, 1);
      pat[29-5*k -: 5] = {obs_oe, obs_out};
    end
  endtask

  task automatic rd_check(input string req, input logic [31:0] a);
    logic [29:0] p;
    run_cycle(0, a, 8'h0, 1, 0, 4'h0, 4'h0, 4'b0100, p);
    chk(req, {2'b0, p}, {2'b0, exp_pat(1, 0, model_rd(a))});
  endtask

  task automatic wr_do(input string req, input logic [31:0] a, input logic [7:0] d);
    logic [29:0] p;
    run_cycle(1, a, d, 1, 0, 4'h0, 4'h0, 4'b0110, p);
    chk(req, {2'b0, p}, {2'b0, exp_pat(hit(a), 1, 8'h0)});
    if (hit(a)) begin
      if (a[22]) bmem[a[MEM_AW-1:0]] = d; else breg[a[REG_AW-1:0]] = d;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [29:0] p;
    logic [31:0] am, ar, ax;
    void'($urandom(32'd4242));
    for (int i = 0; i < (1 << MEM_AW); i++) bmem[i] = 8'h0;
    for (int i = 0; i < (1 << REG_AW); i++) breg[i] = 8'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step(1, 4'hF, 1);
    chk("R12 bus released after reset", {31'b0, obs_oe}, 32'h0);

    am = mk_addr(7'h7F, ID, 1, 20'h00005);
    ar = mk_addr(7'h00, ID, 0, 20'h00005);
    rd_check("R12 memory reads zero", am);
    rd_check("R12 register reads zero", ar);

    wr_do("R8 write timing", am, 8'hC3);
    rd_check("R9 read returns written byte", am);
    wr_do("R7 register write", ar, 8'h5A);
    rd_check("R7 memory untouched by register write", am);
    rd_check("R7 register read", ar);

    run_cycle(1, am, 8'h11, 1, 0, 4'h0, 4'h5, 4'b0110, p);
    chk("R2 bad start ignored", {2'b0, p}, 32'h0);
    rd_check("R2 no store after bad start", am);

    run_cycle(0, am, 8'h0, 1, 1, 4'h5, 4'h0, 4'b0100, p);
    chk("R1 last frame nibble zero accepted", {2'b0, p}, {2'b0, exp_pat(1, 0, model_rd(am))});
    run_cycle(0, am, 8'h0, 1, 1, 4'h0, 4'h7, 4'b0100, p);
    chk("R1 last frame nibble non-zero ignored", {2'b0, p}, 32'h0);

    run_cycle(1, am, 8'h22, 0, 0, 4'h0, 4'h0, 4'b0110, p);
    chk("R4 late select ignored", {2'b0, p}, 32'h0);
    rd_check("R4 no store with late select", am);

    run_cycle(0, am, 8'h0, 1, 0, 4'h0, 4'h0, 4'b0010, p);
    chk("R3 unknown cycle type ignored", {2'b0, p}, 32'h0);

    ax = mk_addr(7'h55, ID, 1, 20'h00005);
    wr_do("R5 mixed upper bits ignored", ax, 8'h33);
    rd_check("R5 no store for mixed upper bits", am);

    for (int b = 0; b < 4; b++) begin
      ax = mk_addr(7'h7F, ID ^ (4'b1 << b), 1, 20'h00005);
      wr_do("R6 ID mismatch ignored", ax, 8'h44);
    end
    rd_check("R6 no store on ID mismatch", am);

    step(1, 4'hF, 0); step(0, 4'h0, 0); step(1, 4'b0110, 0);
    for (int i = 0; i < 8; i++) step(1, am[31-4*i -: 4], 0);
    step(1, 4'h9, 0); step(1, 4'h9, 0); step(1, 4'hF, 0); step(1, 4'hF, 0);
    step(0, 4'h0, 1);
    chk("R11 sync driven before abort", {27'b0, obs_oe, obs_out}, 32'h10);
    step(1, 4'hF, 1);
    chk("R11 released after abort", {31'b0, obs_oe}, 32'h0);
    step(1, 4'hF, 1);
    rd_check("R11 aborted write not stored", am);

    step(1, 4'hF, 0); step(0, 4'h0, 0); step(1, 4'b0100, 0);
    for (int i = 0; i < 8; i++) step(1, am[31-4*i -: 4], 0);
    step(1, 4'hF, 0); step(1, 4'hF, 0); step(1, 4'hF, 1);
    step(0, 4'h0, 1);
    chk("R11 read data phase before abort", {31'b0, obs_oe}, 32'h1);
    step(1, 4'hF, 1);
    chk("R11 read abort releases bus", {31'b0, obs_oe}, 32'h0);
    step(1, 4'hF, 1);

    for (int n = 0; n < 120; n++) begin
      logic [6:0] up;
      logic [3:0] id;
      logic [31:0] a;
      int k = $urandom % 8;
      up = (k < 3) ? 7'h00 : (k < 6) ? 7'h7F : 7'($urandom);
      id = ($urandom % 4 == 0) ? 4'($urandom) : ID;
      a  = mk_addr(up, id, 1'($urandom), {12'h0, 8'($urandom)});
      if ($urandom % 2) wr_do("R8 random write", a, 8'($urandom));
      else begin
        run_cycle(0, a, 8'h0, 1, 0, 4'h0, 4'h0, 4'b0100, p);
        chk("R9 random read", {2'b0, p}, {2'b0, exp_pat(hit(a), 0, model_rd(a))});
      end
    end
    step(1, 4'hF, 1);
    chk("R10 bus idle at end", {27'b0, obs_oe, obs_out}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule